// File: doc/BRIEF.md
# Vectored Priority Interrupt Arbiter

This block sits between a group of interrupt-raising peripherals and a processor that has a single interrupt input. Each peripheral drives its own request line. The arbiter folds those requests into one interrupt toward the processor, but only for requests that software has unmasked while the block is globally enabled.

When the processor acknowledges, the arbiter picks one channel by fixed priority and captures it. It then raises that channel's grant line and returns a byte that software programmed for that channel. The processor uses this byte as an index into a table of up to 256 service-routine addresses, so a routine can move in memory without any change to the peripheral.

Software configures the block through byte writes on a simple memory-mapped bus. There are four registers in consecutive locations from a base address: the channel mask, one table index per channel, and the global enable.

Top module: `irq_vector_arbiter`

## Requirements
- R1: After synchronous reset, the mask, every index and the enable register hold 0. `irq_out`, `grant`, `vec_oe` and `vec_data` are all 0.
- R2: A write with `bus_we` high at a clock edge stores `bus_wdata` into the register whose address matches `bus_addr` exactly. The map is: BASE+0 is the mask (bit n unmasks channel n), BASE+1+n is the index of channel n, and BASE+1+NUM_CH is the enable. The block counts as enabled when the enable register is nonzero.
- R3: `irq_out` is high in the same cycle exactly when the block is enabled and at least one request with its mask bit set is high.
- R4: At the first clock edge where `ack_in` is sampled high after being sampled low, the arbiter captures a winner. The winner is the lowest-numbered enabled, unmasked, requesting channel. `grant` becomes one-hot on that channel at that edge.
- R5: While `ack_in` is high and a grant is held, `vec_oe` is high and `vec_data` carries the captured index of the granted channel. At all other times `vec_oe` is low and `vec_data` is 0.
- R6: While `ack_in` stays high, neither `grant` nor `vec_data` changes. This holds even if requests change or the index registers are rewritten.
- R7: When `ack_in` falls, `vec_oe` drops in the same cycle, and `grant` clears at the first clock edge that samples `ack_in` low.
- R8: If the block is disabled, or no unmasked request is present when acknowledge begins, no grant is raised and `vec_oe` stays low for the whole acknowledge.
- R9: Writes to any address outside the register map, and bus cycles with `bus_we` low, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Write address from the processor bus |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| irq_req | input | NUM_CH | Request line per peripheral |
| ack_in | input | 1 | Interrupt acknowledge from the processor |
| irq_out | output | 1 | Interrupt to the processor |
| grant | output | NUM_CH | One-hot acknowledge to the winning peripheral |
| vec_data | output | 8 | Table index returned during acknowledge |
| vec_oe | output | 1 | High while `vec_data` should be driven onto the data bus |

## Verification
The bench builds the block with its default two channels, a 16-bit address and base 0xFFF0. This small configuration makes an exhaustive sweep practical: the bench covers every mask value, both enable states and every request pattern. For each combination it checks the interrupt, and then runs a full acknowledge, checking the granted channel, the returned index and the release of the grant. Directed cases add a higher-priority request and an index rewrite during an acknowledge, plus writes to mirror and neighbouring addresses, which probe the capture and the exact address decode.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // acknowledge sequencer states
    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,   // no acknowledge in progress
        ACK_HELD  = 2'd1,   // acknowledge open, a channel is granted
        ACK_EMPTY = 2'd2    // acknowledge open, nothing was pending
    } ack_state_e;

endpackage

// File: rtl/irq_arb_regs.sv
module irq_arb_regs
    import irq_arb_pkg::*;
#(
    parameter int                NUM_CH    = 2,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFFF0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  byte_t                    bus_wdata,
    input  logic                     bus_we,
    output logic [NUM_CH-1:0]        mask,
    output logic [NUM_CH*BYTE_W-1:0] idx_flat,
    output logic                     enabled
);

    localparam logic [ADDR_W-1:0] MASK_ADDR = BASE_ADDR;
    localparam logic [ADDR_W-1:0] EN_ADDR   = BASE_ADDR + ADDR_W'(NUM_CH + 1);

    byte_t en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
            en_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == MASK_ADDR) mask <= bus_wdata[NUM_CH-1:0];
            if (bus_addr == EN_ADDR)   en_q <= bus_wdata;
        end
    end

    assign enabled = |en_q;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_idx
            localparam logic [ADDR_W-1:0] IDX_ADDR = BASE_ADDR + ADDR_W'(g + 1);
            always_ff @(posedge clk) begin
                if (rst)
                    idx_flat[g*BYTE_W +: BYTE_W] <= '0;
                else if (bus_we && bus_addr == IDX_ADDR)
                    idx_flat[g*BYTE_W +: BYTE_W] <= bus_wdata;
            end
        end
        if (NUM_CH < BYTE_W) begin : g_spare
            logic unused_mask_bits;
            assign unused_mask_bits = ^bus_wdata[BYTE_W-1:NUM_CH];
        end
    endgenerate

    // R2: a write to the mask location lands in the mask one edge later
    a_r2_mask_write: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == MASK_ADDR) |=> mask == $past(bus_wdata[NUM_CH-1:0]));

    // R9: without a write strobe the enable register holds its value
    a_r9_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> $stable(en_q));

endmodule

// File: rtl/irq_arb_select.sv
module irq_arb_select #(
    parameter int NUM_CH = 2
) (
    input  logic [NUM_CH-1:0] irq_req,
    input  logic [NUM_CH-1:0] mask,
    input  logic              enabled,
    output logic              any_pending,
    output logic [NUM_CH-1:0] winner
);

    logic [NUM_CH-1:0] pend;

    assign pend        = enabled ? (irq_req & mask) : '0;
    assign any_pending = |pend;

    // fixed priority: lowest channel number wins
    always_comb begin
        logic taken;
        taken  = 1'b0;
        winner = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (pend[i] && !taken) begin
                winner[i] = 1'b1;
                taken     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_arb_ack.sv
module irq_arb_ack
    import irq_arb_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ack_in,
    input  logic [NUM_CH-1:0]        winner,
    input  logic [NUM_CH*BYTE_W-1:0] idx_flat,
    output logic [NUM_CH-1:0]        grant,
    output byte_t                    vec_data,
    output logic                     vec_oe
);

    ack_state_e state;
    byte_t      sel_idx;
    byte_t      vec_lat;
    logic       ack_start;

    always_comb begin
        sel_idx = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (winner[i]) sel_idx = idx_flat[i*BYTE_W +: BYTE_W];
    end

    assign ack_start = ack_in && (state == ACK_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ACK_IDLE;
            grant   <= '0;
            vec_lat <= '0;
        end else if (!ack_in) begin
            state <= ACK_IDLE;
            grant <= '0;
        end else if (ack_start) begin
            state   <= (|winner) ? ACK_HELD : ACK_EMPTY;
            grant   <= winner;
            vec_lat <= sel_idx;
        end
    end

    assign vec_oe   = ack_in && (state == ACK_HELD);
    assign vec_data = vec_oe ? vec_lat : '0;

    // R4: at most one channel granted
    a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R4: channel 0 wins whenever it is pending at acknowledge start
    a_r4_prio: assert property (@(posedge clk) disable iff (rst)
        (ack_start && winner[0]) |=> grant[0]);

    // R6: an open acknowledge keeps its grant
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (ack_in && state != ACK_IDLE) |=> ($stable(grant) && $stable(vec_lat)));

    // R7: acknowledge low clears the grant at that edge
    a_r7_drop: assert property (@(posedge clk) disable iff (rst)
        !ack_in |=> grant == '0);

    // R8: acknowledge with nothing pending grants nobody
    a_r8_empty: assert property (@(posedge clk) disable iff (rst)
        (ack_start && winner == '0) |=> grant == '0);

endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
    import irq_arb_pkg::*;
#(
    parameter int                NUM_CH    = 2,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFFF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    input  logic [NUM_CH-1:0] irq_req,
    input  logic              ack_in,
    output logic              irq_out,
    output logic [NUM_CH-1:0] grant,
    output logic [7:0]        vec_data,
    output logic              vec_oe
);

    logic [NUM_CH-1:0]        mask;
    logic [NUM_CH*BYTE_W-1:0] idx_flat;
    logic                     enabled;
    logic [NUM_CH-1:0]        winner;
    logic                     any_pending;

    irq_arb_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_we   (bus_we),
        .mask     (mask),
        .idx_flat (idx_flat),
        .enabled  (enabled)
    );

    irq_arb_select #(.NUM_CH(NUM_CH)) u_sel (
        .irq_req    (irq_req),
        .mask       (mask),
        .enabled    (enabled),
        .any_pending(any_pending),
        .winner     (winner)
    );

    irq_arb_ack #(.NUM_CH(NUM_CH)) u_ack (
        .clk     (clk),
        .rst     (rst),
        .ack_in  (ack_in),
        .winner  (winner),
        .idx_flat(idx_flat),
        .grant   (grant),
        .vec_data(vec_data),
        .vec_oe  (vec_oe)
    );

    assign irq_out = any_pending;

    // R3: disabled block never interrupts
    a_r3_quiet: assert property (@(posedge clk) disable iff (rst)
        !enabled |-> !irq_out);

    // R5: a granted channel was acknowledged at the previous edge
    a_r5_after_ack: assert property (@(posedge clk) disable iff (rst)
        (|grant) |-> $past(ack_in));

endmodule

// File: tb/tb_irq_vector_arbiter.sv
module tb_irq_vector_arbiter;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_we;
    logic [1:0]  irq_req;
    logic        ack_in;
    logic        irq_out;
    logic [1:0]  grant;
    logic [7:0]  vec_data;
    logic        vec_oe;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    irq_vector_arbiter dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .irq_req(irq_req), .ack_in(ack_in),
        .irq_out(irq_out), .grant(grant), .vec_data(vec_data), .vec_oe(vec_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    // open acknowledge, check captured result, close and check release
    task automatic ack_cycle(input string tag, input logic [1:0] eg, input logic [7:0] ed);
        @(negedge clk);
        ack_in = 1'b1;
        @(negedge clk);
        chk({tag, " R4 grant"}, int'(grant), int'(eg));
        chk({tag, " R5 vec_oe"}, int'(vec_oe), int'(eg != 0));
        chk({tag, " R5 vec_data"}, int'(vec_data), int'(ed));
        ack_in = 1'b0;
        #1;
        chk({tag, " R7 oe drop"}, int'(vec_oe), 0);
        @(negedge clk);
        chk({tag, " R7 grant drop"}, int'(grant), 0);
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
        irq_req = 2'b11; ack_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state, requests present but nothing unmasked
        chk("R1 irq_out", int'(irq_out), 0);
        chk("R1 grant", int'(grant), 0);
        chk("R1 vec_oe", int'(vec_oe), 0);
        chk("R1 vec_data", int'(vec_data), 0);
        ack_cycle("R1 R8 reset ack", 2'b00, 8'h00);

        // exhaustive sweep: mask x enable x requests
        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 2; e++) begin
                for (int r = 0; r < 4; r++) begin
                    logic [7:0] i0, i1;
                    logic [1:0] pm, eg;
                    logic [7:0] ed;
                    i0 = 8'((m * 8 + e * 4 + r) * 7 + 13);
                    i1 = 8'((m * 8 + e * 4 + r) * 11 + 17);
                    wr(16'hFFF0, 8'(m));          // R2 mask
                    wr(16'hFFF1, i0);             // R2 channel 0 index
                    wr(16'hFFF2, i1);             // R2 channel 1 index
                    wr(16'hFFF3, e ? 8'h80 : 8'h00); // R2 enable, nonzero
                    irq_req = 2'(r);
                    #1;
                    pm = (e != 0) ? (2'(r) & 2'(m)) : 2'b00;
                    chk("R3 irq_out", int'(irq_out), int'(pm != 0));
                    eg = pm[0] ? 2'b01 : (pm[1] ? 2'b10 : 2'b00);
                    ed = pm[0] ? i0 : (pm[1] ? i1 : 8'h00);
                    ack_cycle("R4 R8 sweep", eg, ed);
                end
            end
        end

        // R6: capture at acknowledge start
        wr(16'hFFF0, 8'h03);
        wr(16'hFFF1, 8'h0D);
        wr(16'hFFF2, 8'h11);
        wr(16'hFFF3, 8'h01);
        irq_req = 2'b10;
        @(negedge clk);
        ack_in = 1'b1;
        @(negedge clk);
        chk("R6 initial grant", int'(grant), 2);
        irq_req = 2'b11;
        wr(16'hFFF2, 8'h99);
        @(negedge clk);
        chk("R6 grant held", int'(grant), 2);
        chk("R6 vec_data held", int'(vec_data), 8'h11);
        chk("R3 irq with new req", int'(irq_out), 1);
        ack_in = 1'b0;
        @(negedge clk);
        chk("R7 grant cleared", int'(grant), 0);
        ack_cycle("R4 R2 next ack", 2'b01, 8'h0D);

        // R9: mirror and neighbouring addresses, and no-strobe cycles
        irq_req = 2'b01;
        wr(16'h7FF0, 8'h00);
        wr(16'hFFF4, 8'h00);
        wr(16'hFFE3, 8'h00);
        wr(16'hFFF1 ^ 16'h0100, 8'h55);
        @(negedge clk);
        bus_addr = 16'hFFF3; bus_wdata = 8'h00; bus_we = 1'b0;
        @(negedge clk);
        bus_addr = 16'hFFF1; bus_wdata = 8'h77;
        @(negedge clk);
        chk("R9 irq kept", int'(irq_out), 1);
        ack_cycle("R9 index kept", 2'b01, 8'h0D);

        // R8: disabling holds pending requests off
        wr(16'hFFF3, 8'h00);
        irq_req = 2'b11;
        #1;
        chk("R8 irq off", int'(irq_out), 0);
        ack_cycle("R8 disabled ack", 2'b00, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule